// File: doc/BRIEF.md
# Exclusive Flash Access Arbiter

This block arbitrates one serial flash controller between two command sources. The first source fires register-triggered commands and collects their results from a receive buffer. The second source is a bus master that runs memory-mapped reads. That bus master can claim the flash for its own use through a request/grant handshake. While it holds the grant, every register-triggered command is refused and a sticky error flag records the refusal.

When the grant may be given depends on a buffer-read mode bit. That bit says which bus drains the receive buffer. In the shared-bus mode (value 0, the reset value), draining the buffer could stall behind a waiting memory-mapped access. The grant is therefore held back until the running command has finished, the buffer is empty and no receive DMA read is outstanding. In the separate-bus mode (value 1), the grant follows as soon as the running command has finished.

The serial engine, the buffer and the bus logic are outside this block. They appear only as status inputs: command done, fill level and DMA pending. A request that is never dropped locks out register commands for good, and the block does nothing to prevent this.

Top module: `flash_excl_arb`

## Requirements
- R1: During and right after reset, `excl_gnt`, `ip_busy`, `ip_start`, `err_flag` and `st_mode` are 0, so the buffer-read mode starts at 0 (shared bus).
- R2: With mode 0, `excl_gnt` rises in the cycle after one where `excl_req` is 1, `ip_busy` is 0, `rx_fill` is 0 and `rx_dma_pend` is all zeros. It never rises otherwise.
- R3: With mode 1, `excl_gnt` rises in the cycle after one where `excl_req` is 1 and `ip_busy` is 0. Fill level and DMA pending are ignored.
- R4: An `ip_trig` pulse in a cycle where `excl_req` or `excl_gnt` is 1 gives no `ip_start`, and `err_flag` is 1 in the next cycle.
- R5: `err_flag` stays set until a cycle with `err_clr` = 1 clears it on the next edge. A clear and a rejection in the same cycle leave it set.
- R6: `excl_gnt` falls in the cycle after `excl_req` is seen low. From that cycle on, `ip_trig` is accepted again.
- R7: A command already running when the request arrives keeps `ip_busy` high until `ip_done`. The grant comes no earlier than the cycle after `ip_busy` falls.
- R8: If the grant condition and an `ip_trig` occur in the same cycle with `excl_req` high, the grant is given and the trigger is rejected.
- R9: While `excl_req` stays high, `excl_gnt` stays high whatever the fill level or DMA pending does. Triggers stay rejected.
- R10: An `ip_trig` with no request, no grant and `ip_busy` low gives a one-cycle `ip_start` and `ip_busy` = 1 in the next cycle. A trigger while busy is dropped without setting `err_flag`.
- R11: `st_mode` follows a `mode_we` write on the next edge. `st_fill` and `st_dma` show the inputs one cycle late.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_we | input | 1 | Write strobe for the buffer-read mode bit |
| mode_wdata | input | 1 | New mode: 0 shared bus, 1 separate bus |
| excl_req | input | 1 | Exclusive access request from the bus master |
| excl_gnt | output | 1 | Exclusive access grant (also the grant status bit) |
| ip_trig | input | 1 | Register-command trigger pulse |
| ip_start | output | 1 | One-cycle start to the serial engine for an accepted command |
| ip_done | input | 1 | Serial engine finished the running command |
| ip_busy | output | 1 | A register command is running |
| rx_fill | input | FILL_W | Receive buffer fill level |
| rx_dma_pend | input | DMA_CH | Receive DMA read pending, one bit per channel |
| err_clr | input | 1 | Write-one-to-clear for the error flag |
| err_flag | output | 1 | Sticky rejected-command error flag |
| st_mode | output | 1 | Current buffer-read mode bit |
| st_fill | output | FILL_W | Registered fill level status |
| st_dma | output | DMA_CH | Registered DMA pending status |

## Verification
The grant is tried in both modes with a command still running and a non-empty buffer plus a pending DMA read. The buffer and the DMA are cleared one at a time, so a grant that ignores one gate, or that waits on the wrong ones in mode 1, shows up in a distinct cycle. Triggers are placed before the request, while it waits, in the same cycle as the grant condition, during the grant and in the release cycle. These placements tell a rejection window that is too short from one that is too long. Clear-with-reject, a trigger while busy and buffer changes under a held grant separate the sticky flag, the silent drop and the held grant from their faulty variants.

// File: rtl/fea_pkg.sv
package fea_pkg;
  // Which bus drains the receive buffer; decides the grant gating.
  typedef enum logic {
    RXRD_SHARED   = 1'b0,
    RXRD_SEPARATE = 1'b1
  } rxrd_mode_e;
endpackage

// File: rtl/fea_ip_track.sv
module fea_ip_track (
  input  logic clk,
  input  logic rst,
  input  logic trig,
  input  logic blocked,
  input  logic done,
  output logic reject,
  output logic start_q,
  output logic busy_q
);
  logic accept;

  always_comb begin
    accept = trig & ~blocked & ~busy_q;
    reject = trig & blocked;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      start_q <= 1'b0;
    end else begin
      start_q <= accept;
      if (accept)
        busy_q <= 1'b1;
      else if (done)
        busy_q <= 1'b0;
    end
  end
endmodule

// File: rtl/fea_grant_ctrl.sv
module fea_grant_ctrl
  import fea_pkg::*;
#(
  parameter int FILL_W = 6,
  parameter int DMA_CH = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  rxrd_mode_e        mode,
  input  logic              req,
  input  logic              busy,
  input  logic [FILL_W-1:0] fill,
  input  logic [DMA_CH-1:0] dma_pend,
  output logic              gnt_q
);
  logic dma_any;
  logic drained;
  logic may_grant;

  generate
    if (DMA_CH > 1) begin : g_dma_multi
      assign dma_any = |dma_pend;
    end else begin : g_dma_single
      assign dma_any = dma_pend[0];
    end
  endgenerate

  always_comb begin
    drained   = (fill == '0) & ~dma_any;
    may_grant = ~busy & ((mode == RXRD_SEPARATE) | drained);
  end

  always_ff @(posedge clk) begin
    if (rst)
      gnt_q <= 1'b0;
    else
      gnt_q <= req & (gnt_q | may_grant);
  end
endmodule

// File: rtl/fea_err_flag.sv
module fea_err_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic flag_q
);
  always_ff @(posedge clk) begin
    if (rst)
      flag_q <= 1'b0;
    else if (set)
      flag_q <= 1'b1;
    else if (clr)
      flag_q <= 1'b0;
  end
endmodule

// File: rtl/fea_status.sv
module fea_status
  import fea_pkg::*;
#(
  parameter int FILL_W = 6,
  parameter int DMA_CH = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_we,
  input  logic              mode_wdata,
  input  logic [FILL_W-1:0] fill,
  input  logic [DMA_CH-1:0] dma_pend,
  output rxrd_mode_e        mode_q,
  output logic [FILL_W-1:0] fill_q,
  output logic [DMA_CH-1:0] dma_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= RXRD_SHARED;
      fill_q <= '0;
      dma_q  <= '0;
    end else begin
      if (mode_we)
        mode_q <= rxrd_mode_e'(mode_wdata);
      fill_q <= fill;
      dma_q  <= dma_pend;
    end
  end
endmodule

// File: rtl/flash_excl_arb.sv
module flash_excl_arb
  import fea_pkg::*;
#(
  parameter int FILL_W = 6,
  parameter int DMA_CH = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_we,
  input  logic              mode_wdata,
  input  logic              excl_req,
  output logic              excl_gnt,
  input  logic              ip_trig,
  output logic              ip_start,
  input  logic              ip_done,
  output logic              ip_busy,
  input  logic [FILL_W-1:0] rx_fill,
  input  logic [DMA_CH-1:0] rx_dma_pend,
  input  logic              err_clr,
  output logic              err_flag,
  output logic              st_mode,
  output logic [FILL_W-1:0] st_fill,
  output logic [DMA_CH-1:0] st_dma
);
  rxrd_mode_e mode_q;
  logic       gnt_q;
  logic       busy_q;
  logic       ip_reject;
  logic       ip_blocked;

  // A request (pending or granted) or a held grant closes the command path.
  assign ip_blocked = excl_req | gnt_q;

  fea_status #(.FILL_W(FILL_W), .DMA_CH(DMA_CH)) u_status (
    .clk        (clk),
    .rst        (rst),
    .mode_we    (mode_we),
    .mode_wdata (mode_wdata),
    .fill       (rx_fill),
    .dma_pend   (rx_dma_pend),
    .mode_q     (mode_q),
    .fill_q     (st_fill),
    .dma_q      (st_dma)
  );

  fea_ip_track u_ip (
    .clk     (clk),
    .rst     (rst),
    .trig    (ip_trig),
    .blocked (ip_blocked),
    .done    (ip_done),
    .reject  (ip_reject),
    .start_q (ip_start),
    .busy_q  (busy_q)
  );

  fea_grant_ctrl #(.FILL_W(FILL_W), .DMA_CH(DMA_CH)) u_gnt (
    .clk      (clk),
    .rst      (rst),
    .mode     (mode_q),
    .req      (excl_req),
    .busy     (busy_q),
    .fill     (rx_fill),
    .dma_pend (rx_dma_pend),
    .gnt_q    (gnt_q)
  );

  fea_err_flag u_err (
    .clk    (clk),
    .rst    (rst),
    .set    (ip_reject),
    .clr    (err_clr),
    .flag_q (err_flag)
  );

  assign excl_gnt = gnt_q;
  assign ip_busy  = busy_q;
  assign st_mode  = mode_q;
endmodule

// File: rtl/fea_arb_chk.sv
module fea_arb_chk #(
  parameter int FILL_W = 6,
  parameter int DMA_CH = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              excl_req,
  input logic              excl_gnt,
  input logic              ip_trig,
  input logic              ip_start,
  input logic              ip_done,
  input logic              ip_busy,
  input logic [FILL_W-1:0] rx_fill,
  input logic [DMA_CH-1:0] rx_dma_pend,
  input logic              err_clr,
  input logic              err_flag,
  input logic              st_mode
);
  // R2
  gnt_shared_gate_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(excl_gnt) && !st_mode) |-> $past(!ip_busy && rx_fill == '0 && rx_dma_pend == '0));
  // R3
  gnt_after_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(excl_gnt) |-> $past(!ip_busy && excl_req));
  // R4
  reject_sets_err_chk: assert property (@(posedge clk) disable iff (rst)
    (ip_trig && (excl_req || excl_gnt)) |=> (err_flag && !ip_start));
  // R5
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (err_flag && !err_clr) |=> err_flag);
  // R6
  gnt_release_chk: assert property (@(posedge clk) disable iff (rst)
    !excl_req |=> !excl_gnt);
  // R7
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ip_busy && !ip_done) |=> ip_busy);
  // R9
  gnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (excl_gnt && excl_req) |=> excl_gnt);
  // R10
  no_start_in_gnt_chk: assert property (@(posedge clk) disable iff (rst)
    !(ip_start && excl_gnt));
  // R10
  start_from_idle_chk: assert property (@(posedge clk) disable iff (rst)
    ip_start |-> $past(!ip_busy && ip_trig));
endmodule

bind flash_excl_arb fea_arb_chk #(.FILL_W(FILL_W), .DMA_CH(DMA_CH)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .excl_req    (excl_req),
  .excl_gnt    (excl_gnt),
  .ip_trig     (ip_trig),
  .ip_start    (ip_start),
  .ip_done     (ip_done),
  .ip_busy     (ip_busy),
  .rx_fill     (rx_fill),
  .rx_dma_pend (rx_dma_pend),
  .err_clr     (err_clr),
  .err_flag    (err_flag),
  .st_mode     (st_mode)
);

// File: tb/tb_flash_excl_arb.sv
module tb_flash_excl_arb;
  localparam int FW = 6;
  localparam int DC = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_we = 0, mode_wdata = 0, excl_req = 0, ip_trig = 0, ip_done = 0, err_clr = 0;
  logic [FW-1:0] rx_fill = '0;
  logic [DC-1:0] rx_dma_pend = '0;
  logic excl_gnt, ip_start, ip_busy, err_flag, st_mode;
  logic [FW-1:0] st_fill;
  logic [DC-1:0] st_dma;

  always #2 clk = ~clk;

  flash_excl_arb #(.FILL_W(FW), .DMA_CH(DC)) dut (
    .clk(clk), .rst(rst), .mode_we(mode_we), .mode_wdata(mode_wdata),
    .excl_req(excl_req), .excl_gnt(excl_gnt), .ip_trig(ip_trig), .ip_start(ip_start),
    .ip_done(ip_done), .ip_busy(ip_busy), .rx_fill(rx_fill), .rx_dma_pend(rx_dma_pend),
    .err_clr(err_clr), .err_flag(err_flag), .st_mode(st_mode), .st_fill(st_fill), .st_dma(st_dma)
  );

  typedef struct {
    logic gnt, err, busy, start, mode;
    logic [FW-1:0] fill;
    logic [DC-1:0] dma;
    string tag;
  } exp_t;

  exp_t sb[$];
  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  // Model state built from the requirements.
  logic m_gnt = 0, m_err = 0, m_busy = 0, m_mode = 0;

  task automatic step(input string tag, input logic req, input logic trig, input logic done,
                      input logic [FW-1:0] fill, input logic [DC-1:0] dma,
                      input logic clr, input logic mwe, input logic md);
    exp_t e;
    logic may, acc, rej;
    @(negedge clk);
    excl_req = req; ip_trig = trig; ip_done = done; rx_fill = fill;
    rx_dma_pend = dma; err_clr = clr; mode_we = mwe; mode_wdata = md;
    may = !m_busy && (m_mode || (fill == '0 && dma == '0));
    acc = trig && !req && !m_gnt && !m_busy;
    rej = trig && (req || m_gnt);
    m_gnt  = req && (m_gnt || may);
    m_busy = acc || (m_busy && !done);
    m_err  = rej || (m_err && !clr);
    m_mode = mwe ? md : m_mode;
    e.gnt = m_gnt; e.err = m_err; e.busy = m_busy; e.start = acc;
    e.mode = m_mode; e.fill = fill; e.dma = dma; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic idle(input string tag, input int n);
    for (int i = 0; i < n; i++) step(tag, 0, 0, 0, '0, '0, 0, 0, 0);
  endtask

  // Monitor: compares one expected item per clock, 1 ns after the edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t e;
        bit bad;
        e = sb.pop_front();
        bad = 0;
        n_chk++;
        if (excl_gnt !== e.gnt) begin bad = 1; $display("FAIL %s excl_gnt act=%b exp=%b", e.tag, excl_gnt, e.gnt); end
        if (err_flag !== e.err) begin bad = 1; $display("FAIL %s err_flag act=%b exp=%b", e.tag, err_flag, e.err); end
        if (ip_busy !== e.busy) begin bad = 1; $display("FAIL %s ip_busy act=%b exp=%b", e.tag, ip_busy, e.busy); end
        if (ip_start !== e.start) begin bad = 1; $display("FAIL %s ip_start act=%b exp=%b", e.tag, ip_start, e.start); end
        if (st_mode !== e.mode) begin bad = 1; $display("FAIL %s st_mode act=%b exp=%b", e.tag, st_mode, e.mode); end
        if (st_fill !== e.fill) begin bad = 1; $display("FAIL %s st_fill act=%0d exp=%0d", e.tag, st_fill, e.fill); end
        if (st_dma !== e.dma) begin bad = 1; $display("FAIL %s st_dma act=%b exp=%b", e.tag, st_dma, e.dma); end
        if (bad) n_fail++;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_chk++; // R1 reset state while reset is held
    if ({excl_gnt, ip_busy, ip_start, err_flag, st_mode} !== 5'b0) begin
      n_fail++;
      $display("FAIL R1 reset outputs act=%b exp=00000", {excl_gnt, ip_busy, ip_start, err_flag, st_mode});
    end
    rst = 0;
    idle("R1", 2);

    // R10: accept from idle, drop while busy, finish
    step("R10", 0, 1, 0, '0, '0, 0, 0, 0);
    step("R10", 0, 1, 0, '0, '0, 0, 0, 0);
    step("R10", 0, 0, 1, '0, '0, 0, 0, 0);
    step("R11", 0, 0, 0, 6'd9, 2'b10, 0, 0, 0);

    // R2, R7: mode 0, command running, buffer and DMA gate the grant
    step("R7", 0, 1, 0, 6'd4, 2'b01, 0, 0, 0);
    step("R7", 1, 0, 0, 6'd4, 2'b01, 0, 0, 0);
    step("R7", 1, 1, 0, 6'd4, 2'b01, 0, 0, 0);   // R4 reject while pending
    step("R5", 1, 0, 0, 6'd4, 2'b01, 1, 0, 0);   // clear
    step("R7", 1, 0, 1, 6'd4, 2'b01, 0, 0, 0);   // done
    step("R2", 1, 0, 0, 6'd4, 2'b01, 0, 0, 0);
    step("R2", 1, 0, 0, 6'd0, 2'b01, 0, 0, 0);
    step("R2", 1, 0, 0, 6'd2, 2'b00, 0, 0, 0);
    step("R2", 1, 0, 0, 6'd0, 2'b00, 0, 0, 0);   // grant next
    step("R9", 1, 0, 0, 6'd7, 2'b11, 0, 0, 0);
    step("R9", 1, 0, 0, 6'd7, 2'b11, 0, 0, 0);
    step("R4", 1, 1, 0, 6'd0, 2'b00, 0, 0, 0);
    step("R5", 1, 0, 0, 6'd0, 2'b00, 0, 0, 0);
    step("R5", 1, 1, 0, 6'd0, 2'b00, 1, 0, 0);   // clear + reject -> set
    step("R5", 1, 0, 0, 6'd0, 2'b00, 1, 0, 0);   // clear -> low
    // R6: drop request, trigger in release cycle rejected, then accepted
    step("R6", 0, 1, 0, '0, '0, 0, 0, 0);
    step("R6", 0, 0, 0, '0, '0, 1, 0, 0);
    step("R6", 0, 1, 0, '0, '0, 0, 0, 0);
    step("R6", 0, 0, 1, '0, '0, 0, 0, 0);

    // R11 / R3: switch to mode 1, grant ignores buffer and DMA
    step("R11", 0, 0, 0, '0, '0, 0, 1, 1);
    step("R3", 0, 1, 0, 6'd5, 2'b11, 0, 0, 0);
    step("R3", 1, 0, 0, 6'd5, 2'b11, 0, 0, 0);
    step("R3", 1, 0, 1, 6'd5, 2'b11, 0, 0, 0);
    step("R3", 1, 0, 0, 6'd5, 2'b11, 0, 0, 0);   // grant next
    step("R3", 1, 0, 0, 6'd5, 2'b11, 0, 0, 0);
    step("R6", 0, 0, 0, 6'd5, 2'b11, 1, 0, 0);
    step("R6", 0, 0, 0, '0, '0, 0, 0, 0);

    // R8: grant condition and trigger together with request
    step("R8", 1, 1, 0, 6'd3, 2'b01, 0, 0, 0);
    step("R8", 1, 0, 0, '0, '0, 0, 0, 0);
    step("R8", 0, 0, 0, '0, '0, 1, 0, 0);
    // back to mode 0: same pattern must now wait
    step("R11", 0, 0, 0, '0, '0, 0, 1, 0);
    step("R2", 1, 1, 0, 6'd3, 2'b00, 0, 0, 0);
    step("R2", 1, 0, 0, 6'd3, 2'b00, 0, 0, 0);
    step("R2", 1, 0, 0, 6'd0, 2'b00, 0, 0, 0);
    step("R9", 1, 0, 0, 6'd0, 2'b00, 0, 0, 0);
    idle("R6", 3);

    @(posedge clk); #2;
    @(posedge clk); #2;
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule